// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a double-buffered 12-bit serial DAC. A client hands it a code over a valid/ready handshake. The sequencer then pulls the active-low select line low and shifts the code out most significant bit first on a serial clock that it generates itself. It raises select again and strobes the active-low load line, which moves the shifted word into the converter's output register. A one-cycle completion pulse closes each write.

A separate clear request drives the converter's active-low clear line for a minimum width, which forces the analog output to zero scale. Every interval on the serial side is derived from a nanosecond minimum and the system clock period, rounded up to whole cycles. A parameter chooses between the low-supply (3 V) and high-supply (5 V) set of minima. With the default 20 ns clock and the 3 V profile, the minima are as follows:

- clock high and clock low: 2 cycles each
- select before the first rising clock edge: 2 cycles
- select held after the last rising edge: 2 cycles
- data setup and data hold: 1 cycle each
- load delay after the last rising edge: 1 cycle
- load width: 3 cycles
- recovery after load: 2 cycles
- clear width: 2 cycles

Top module: `dac_wr_seq`

## Requirements
- R1: After reset, select, load and clear are high, the serial clock is low, ready is high and done is low.
- R2: Each accepted code is sent as exactly 12 rising serial clock edges, most significant bit first. The receiver samples data on the rising edge, and the data line does not change while the serial clock is high.
- R3: The serial clock stays high for at least 2 cycles and low for at least 2 cycles between rising edges. Data is stable at least 1 cycle before each rising edge and at least 1 cycle after it.
- R4: The serial clock rises only while select is low. Select falls at least 2 cycles before the first rising edge and rises no sooner than 2 cycles after the last one.
- R5: Load falls only while select is high and at least 1 cycle after the last rising edge. It stays low for at least 3 cycles, and the serial clock is never high while load is low.
- R6: Done pulses for exactly one cycle, no sooner than 2 cycles after load returns high, with load and select both high.
- R7: A code is taken only on a cycle where valid and ready are both high. Ready is low for the whole write, so a valid held during a write starts no extra write.
- R8: A clear request produces a clear pulse at least 2 cycles wide, and ready is low while clear is low.
- R9: A clear request that arrives during a write, or in the same cycle that a code is accepted, is held. Clear falls only after that write's done pulse, with select and load high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| code_i | input | 12 | Code to send |
| code_valid_i | input | 1 | Code offered |
| code_ready_o | output | 1 | Sequencer can take a code |
| clr_req_i | input | 1 | One-cycle request for a clear pulse |
| done_o | output | 1 | One-cycle pulse when a write completes |
| dac_cs_n_o | output | 1 | Active-low select to the DAC |
| dac_sclk_o | output | 1 | Serial clock to the DAC |
| dac_sdi_o | output | 1 | Serial data to the DAC |
| dac_ld_n_o | output | 1 | Active-low load strobe to the DAC |
| dac_clr_n_o | output | 1 | Active-low clear to the DAC |

## Verification
A clear request can land in the same cycle that a code is accepted, or in any cycle of a running write. The bench provokes the first case by raising valid and the clear request together while ready is high. It provokes the second by pulsing the clear request while select is low. In both cases the scoreboard must still see the queued code arrive intact at the load strobe. The clear pulse must then begin strictly after that write's done pulse, with select and load idle, and exactly one clear pulse must appear per request.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL_LEAD,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_SEL_TRAIL,
        ST_LD_LEAD,
        ST_LD_LOW,
        ST_LD_TRAIL,
        ST_CLR_LOW
    } wr_state_e;

    // Whole cycles that cover a minimum time in ns
    function automatic int ns_to_cyc(input int t_ns, input int per_ns);
        return (t_ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wr_interval_timer.sv
module wr_interval_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] len_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = len_i - 1'b1;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (len_i != '0)); // R3

endmodule

// File: rtl/wr_shift_reg.sv
module wr_shift_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         msb_o
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i)
            sr_d = data_i;
        else if (shift_i)
            sr_d = {sr_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb_o = sr_q[W-1];

    AST_SR_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i)); // R2

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
    import dac_wr_pkg::*;
#(
    parameter int W          = 12,
    parameter int CLK_NS     = 20,
    parameter bit PROFILE_5V = 1'b0,
    parameter int CNT_W      = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code_i,
    input  logic         code_valid_i,
    output logic         code_ready_o,
    input  logic         clr_req_i,
    output logic         done_o,
    output logic         dac_cs_n_o,
    output logic         dac_sclk_o,
    output logic         dac_sdi_o,
    output logic         dac_ld_n_o,
    output logic         dac_clr_n_o
);

    // Minimum times in ns for the selected supply profile
    localparam int NS_CLK_HI  = PROFILE_5V ? 30 : 40;
    localparam int NS_CLK_LO  = PROFILE_5V ? 30 : 40;
    localparam int NS_DSETUP  = 15;
    localparam int NS_DHOLD   = 15;
    localparam int NS_LD_W    = PROFILE_5V ? 30 : 50;
    localparam int NS_CLR_W   = PROFILE_5V ? 30 : 40;
    localparam int NS_SEL_SU  = PROFILE_5V ? 30 : 40;
    localparam int NS_SEL_HD  = PROFILE_5V ? 30 : 40;
    localparam int NS_LD_SU   = 15;
    localparam int NS_LD_HD   = PROFILE_5V ? 30 : 40;

    // Cycle counts; clock phases also cover data setup and hold
    localparam logic [CNT_W-1:0] C_HI   = CNT_W'(max_of(ns_to_cyc(NS_CLK_HI, CLK_NS), ns_to_cyc(NS_DHOLD, CLK_NS)));
    localparam logic [CNT_W-1:0] C_LO   = CNT_W'(max_of(ns_to_cyc(NS_CLK_LO, CLK_NS), ns_to_cyc(NS_DSETUP, CLK_NS)));
    localparam logic [CNT_W-1:0] C_SELL = CNT_W'(max_of(ns_to_cyc(NS_SEL_SU, CLK_NS), ns_to_cyc(NS_DSETUP, CLK_NS)));
    localparam logic [CNT_W-1:0] C_SELT = CNT_W'(ns_to_cyc(NS_SEL_HD, CLK_NS));
    localparam logic [CNT_W-1:0] C_LDL  = CNT_W'(ns_to_cyc(NS_LD_SU, CLK_NS));
    localparam logic [CNT_W-1:0] C_LDW  = CNT_W'(ns_to_cyc(NS_LD_W, CLK_NS));
    localparam logic [CNT_W-1:0] C_LDT  = CNT_W'(ns_to_cyc(NS_LD_HD, CLK_NS));
    localparam logic [CNT_W-1:0] C_CLRW = CNT_W'(ns_to_cyc(NS_CLR_W, CLK_NS));

    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    typedef struct packed {
        wr_state_e     st;
        logic          cs_n;
        logic          sclk;
        logic          ld_n;
        logic          clr_n;
        logic          done;
        logic          clr_pend;
        logic [BW-1:0] bitc;
    } seq_regs_t;

    seq_regs_t n_d, r_q;

    logic             tmr_start;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_exp;
    logic             sr_load;
    logic             sr_shift;
    logic             sdi_w;

    wr_interval_timer #(.CW(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tmr_start),
        .len_i    (tmr_len),
        .expired_o(tmr_exp)
    );

    wr_shift_reg #(.W(W)) u_sr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sr_load),
        .data_i (code_i),
        .shift_i(sr_shift),
        .msb_o  (sdi_w)
    );

    always_comb begin
        n_d          = r_q;
        n_d.done     = 1'b0;
        n_d.clr_pend = r_q.clr_pend | clr_req_i;
        tmr_start    = 1'b0;
        tmr_len      = '0;
        sr_load      = 1'b0;
        sr_shift     = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (r_q.clr_pend) begin
                    n_d.st       = ST_CLR_LOW;
                    n_d.clr_n    = 1'b0;
                    n_d.clr_pend = clr_req_i;
                    tmr_start    = 1'b1;
                    tmr_len      = C_CLRW;
                end else if (code_valid_i) begin
                    n_d.st    = ST_SEL_LEAD;
                    n_d.cs_n  = 1'b0;
                    n_d.bitc  = '0;
                    sr_load   = 1'b1;
                    tmr_start = 1'b1;
                    tmr_len   = C_SELL;
                end
            end
            ST_SEL_LEAD: begin
                if (tmr_exp) begin
                    n_d.st    = ST_CLK_HI;
                    n_d.sclk  = 1'b1;
                    tmr_start = 1'b1;
                    tmr_len   = C_HI;
                end
            end
            ST_CLK_HI: begin
                if (tmr_exp) begin
                    n_d.sclk  = 1'b0;
                    tmr_start = 1'b1;
                    if (r_q.bitc == LAST_BIT) begin
                        n_d.st  = ST_SEL_TRAIL;
                        tmr_len = C_SELT;
                    end else begin
                        n_d.st   = ST_CLK_LO;
                        n_d.bitc = r_q.bitc + 1'b1;
                        sr_shift = 1'b1;
                        tmr_len  = C_LO;
                    end
                end
            end
            ST_CLK_LO: begin
                if (tmr_exp) begin
                    n_d.st    = ST_CLK_HI;
                    n_d.sclk  = 1'b1;
                    tmr_start = 1'b1;
                    tmr_len   = C_HI;
                end
            end
            ST_SEL_TRAIL: begin
                if (tmr_exp) begin
                    n_d.st    = ST_LD_LEAD;
                    n_d.cs_n  = 1'b1;
                    tmr_start = 1'b1;
                    tmr_len   = C_LDL;
                end
            end
            ST_LD_LEAD: begin
                if (tmr_exp) begin
                    n_d.st    = ST_LD_LOW;
                    n_d.ld_n  = 1'b0;
                    tmr_start = 1'b1;
                    tmr_len   = C_LDW;
                end
            end
            ST_LD_LOW: begin
                if (tmr_exp) begin
                    n_d.st    = ST_LD_TRAIL;
                    n_d.ld_n  = 1'b1;
                    tmr_start = 1'b1;
                    tmr_len   = C_LDT;
                end
            end
            ST_LD_TRAIL: begin
                if (tmr_exp) begin
                    n_d.st   = ST_IDLE;
                    n_d.done = 1'b1;
                end
            end
            ST_CLR_LOW: begin
                if (tmr_exp) begin
                    n_d.st    = ST_IDLE;
                    n_d.clr_n = 1'b1;
                end
            end
            default: n_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.cs_n     <= 1'b1;
            r_q.sclk     <= 1'b0;
            r_q.ld_n     <= 1'b1;
            r_q.clr_n    <= 1'b1;
            r_q.done     <= 1'b0;
            r_q.clr_pend <= 1'b0;
            r_q.bitc     <= '0;
        end else begin
            r_q <= n_d;
        end
    end

    assign code_ready_o = (r_q.st == ST_IDLE) && !r_q.clr_pend;
    assign done_o       = r_q.done;
    assign dac_cs_n_o   = r_q.cs_n;
    assign dac_sclk_o   = r_q.sclk;
    assign dac_sdi_o    = sdi_w;
    assign dac_ld_n_o   = r_q.ld_n;
    assign dac_clr_n_o  = r_q.clr_n;

    AST_SCLK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk_o |-> !dac_cs_n_o); // R4
    AST_NO_CLK_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n_o |-> (!dac_sclk_o && dac_cs_n_o)); // R5
    AST_SDI_STABLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sclk_o && $past(dac_sclk_o)) |-> $stable(dac_sdi_o)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (dac_ld_n_o && dac_cs_n_o)); // R6
    AST_READY_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        code_ready_o |-> (dac_cs_n_o && dac_ld_n_o && dac_clr_n_o)); // R7
    AST_CLR_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_clr_n_o) |-> (dac_cs_n_o && dac_ld_n_o)); // R9
    AST_CLR_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n_o |-> !code_ready_o); // R8

endmodule

// File: tb/sim_dac_wr_seq.sv
module sim_dac_wr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] code = '0;
    logic        code_valid = 1'b0;
    logic        code_ready;
    logic        clr_req = 1'b0;
    logic        done;
    logic        cs_n, sclk, sdi, ld_n, clr_n;

    // Expected minima in cycles at 20 ns, 3 V profile
    localparam int E_HI = 2, E_LO = 2, E_SU = 1, E_HD = 1, E_SELL = 2, E_SELT = 2;
    localparam int E_LDL = 1, E_LDW = 3, E_LDT = 2, E_CLRW = 2;

    always #10 clk = ~clk;

    dac_wr_seq u0 (
        .clk(clk), .rst_n(rst_n), .code_i(code), .code_valid_i(code_valid),
        .code_ready_o(code_ready), .clr_req_i(clr_req), .done_o(done),
        .dac_cs_n_o(cs_n), .dac_sclk_o(sclk), .dac_sdi_o(sdi),
        .dac_ld_n_o(ld_n), .dac_clr_n_o(clr_n)
    );

    int n_chk = 0, n_fail = 0;
    logic [11:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: samples outputs at the falling clock edge
    bit   mon_en = 1'b0;
    int   cyc = 0;
    int   t_rise = -1000, t_fall = -1000, t_csf = -1000, t_sdi = -1000;
    int   t_ldf = -1000, t_ldr = -1000, t_done = -1000, t_clrf = -1000, t_clr_on = -1000;
    int   bits = 0, n_frames = 0, n_clrs = 0;
    logic [11:0] word = '0;
    logic p_cs = 1, p_sclk = 0, p_sdi = 0, p_ld = 1, p_clr = 1, p_done = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            cyc++;
            if (sdi !== p_sdi) begin
                if (!cs_n && bits > 0) chk(cyc - t_rise >= E_HD, "R3 data hold", cyc - t_rise, E_HD);
                t_sdi = cyc;
            end
            if (!p_cs && cs_n === 1'b0) begin end
            if (p_cs && !cs_n) begin
                t_csf = cyc; bits = 0; word = '0;
                chk(!code_ready, "R7 ready low in write", code_ready, 0);
            end
            if (!p_sclk && sclk) begin
                chk(!cs_n, "R4 clock with select low", cs_n, 0);
                if (bits == 0) chk(cyc - t_csf >= E_SELL, "R4 select lead", cyc - t_csf, E_SELL);
                else           chk(cyc - t_fall >= E_LO, "R3 clock low", cyc - t_fall, E_LO);
                chk(cyc - t_sdi >= E_SU, "R3 data setup", cyc - t_sdi, E_SU);
                word = {word[10:0], sdi};
                bits++;
                t_rise = cyc;
            end
            if (p_sclk && !sclk) begin
                chk(cyc - t_rise >= E_HI, "R3 clock high", cyc - t_rise, E_HI);
                t_fall = cyc;
            end
            if (!p_cs && cs_n) begin
                chk(bits == 12, "R2 edge count", bits, 12);
                chk(cyc - t_rise >= E_SELT, "R4 select trail", cyc - t_rise, E_SELT);
            end
            if (p_ld && !ld_n) begin
                t_ldf = cyc;
                n_frames++;
                chk(cs_n, "R5 load with select high", cs_n, 1);
                chk(cyc - t_rise >= E_LDL, "R5 load lead", cyc - t_rise, E_LDL);
                if (exp_q.size() == 0) chk(0, "R2 unexpected frame", word, -1);
                else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    chk(word == e, "R2 word", word, e);
                end
            end
            if (!p_ld && ld_n) begin
                chk(cyc - t_ldf >= E_LDW, "R5 load width", cyc - t_ldf, E_LDW);
                t_ldr = cyc;
            end
            if (sclk && !ld_n) chk(0, "R5 clock in load", 1, 0);
            if (done) begin
                chk(!p_done, "R6 done one cycle", p_done, 0);
                chk(cyc - t_ldr >= E_LDT, "R6 load trail", cyc - t_ldr, E_LDT);
                chk(ld_n && cs_n, "R6 lines idle at done", {ld_n, cs_n}, 3);
                t_done = cyc;
            end
            if (p_clr && !clr_n) begin
                t_clrf = cyc; n_clrs++;
                chk(cs_n && ld_n, "R9 clear outside write", {cs_n, ld_n}, 3);
            end
            if (!clr_n) chk(!code_ready, "R8 ready low in clear", code_ready, 0);
            if (!p_clr && clr_n) chk(cyc - t_clrf >= E_CLRW, "R8 clear width", cyc - t_clrf, E_CLRW);
            p_cs = cs_n; p_sclk = sclk; p_sdi = sdi; p_ld = ld_n; p_clr = clr_n; p_done = done;
        end
    end

    // Driver tasks
    task automatic send(input logic [11:0] c);
        @(negedge clk);
        while (!code_ready) @(negedge clk);
        code = c; code_valid = 1'b1;
        exp_q.push_back(c);
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!code_ready);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog timeout in any requirement actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int clrs0, fr0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset levels
        chk(cs_n == 1, "R1 select idle", cs_n, 1);
        chk(ld_n == 1, "R1 load idle", ld_n, 1);
        chk(clr_n == 1, "R1 clear idle", clr_n, 1);
        chk(sclk == 0, "R1 clock idle", sclk, 0);
        chk(code_ready == 1, "R1 ready", code_ready, 1);
        chk(done == 0, "R1 done", done, 0);
        p_sdi = sdi;
        mon_en = 1'b1;

        // R2 R3 R4 R5 R6: several codes
        send(12'hA5C); send(12'hFFF); send(12'h000); send(12'h801);
        wait_idle();

        // R8: clear in idle
        clrs0 = n_clrs;
        pulse_clr();
        wait_idle();
        chk(n_clrs == clrs0 + 1, "R8 clear count", n_clrs, clrs0 + 1);

        // R9: clear during a write
        clrs0 = n_clrs;
        send(12'h5A3);
        pulse_clr();
        wait_idle();
        chk(n_clrs == clrs0 + 1, "R9 deferred clear count", n_clrs, clrs0 + 1);
        chk(t_clrf > t_done, "R9 clear after done", t_clrf, t_done + 1);

        // R9: clear and code in the same cycle
        clrs0 = n_clrs; fr0 = n_frames;
        @(negedge clk);
        while (!code_ready) @(negedge clk);
        code = 12'h7FF; code_valid = 1'b1; clr_req = 1'b1;
        exp_q.push_back(12'h7FF);
        @(negedge clk);
        code_valid = 1'b0; clr_req = 1'b0;
        wait_idle();
        chk(n_frames == fr0 + 1, "R9 code taken first", n_frames, fr0 + 1);
        chk(n_clrs == clrs0 + 1, "R9 same-cycle clear count", n_clrs, clrs0 + 1);
        chk(t_clrf > t_done, "R9 same-cycle clear after done", t_clrf, t_done + 1);

        // R7: valid held during a write is ignored
        fr0 = n_frames;
        send(12'h123);
        code = 12'h3C3; code_valid = 1'b1;
        repeat (10) @(negedge clk);
        code_valid = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk(n_frames == fr0 + 1, "R7 no extra write", n_frames, fr0 + 1);
        chk(code_ready == 1, "R7 ready back", code_ready, 1);

        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule